// File: doc/BRIEF.md
# Register Rename Unit with Checkpoint Recovery

This block translates the logical register numbers of an in-order instruction stream into physical register numbers, accepting at most one instruction per clock. Source operands are looked up in a mapping table. A destination gets a physical register that is currently unused, so the only ordering left between renamed instructions is true read-after-write. Each accepted instruction records three things in a circular history: its logical destination, the newly assigned physical register, and the physical register that the destination named before. When the oldest entry commits, that older physical register is released.

Two recovery paths are provided. A branch takes one of a few checkpoint slots, which holds a full copy of the mapping table. If the branch turns out mispredicted, the copy is restored in one cycle. Every physical register handed out after the branch goes back to the free pool, and younger checkpoints and history entries are dropped. An exception instead walks the history from the newest entry back to the oldest, one entry per cycle, writing each saved previous mapping back into the table. The walk leaves the mapping as it was at the last commit.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i for all 32 logical registers, physical registers 32 to 63 are free, and history and checkpoints are empty.
- R2: Sources are read from the mapping in force before the instruction's own destination is remapped; physPrev shows the current mapping of renDst, even when a source equals the destination.
- R3: An accepted instruction with a destination (renHasDest=1, renIsBranch=0) receives the lowest-numbered free physical register on physDst, and from the next cycle renDst maps to it.
- R4: renReady is low when an instruction needing a destination finds no free physical register, or when the history already holds 64 uncommitted entries.
- R5: A commitValid pulse retires the oldest history entry and frees its previous physical register (an entry with no destination frees nothing); with an empty history it has no effect.
- R6: A branch (renIsBranch=1) never writes a destination, takes the lowest-numbered free checkpoint slot reported on brTag (0 to 3), and is stalled when all four slots are in use.
- R7: brValid with brMispredict=0 releases slot brResTag without changing the mapping.
- R8: brValid with brMispredict=1 restores the mapping saved in slot brResTag in one cycle, frees every physical register allocated after that branch, and discards younger history entries and checkpoints.
- R9: excValid undoes all uncommitted history entries newest first, one per cycle, freeing their new registers and releasing all checkpoints; renReady stays low until the walk ends.
- R10: In a cycle with excValid or a mispredict, renReady is low and neither rename nor commit takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | Instruction offered for renaming |
| renHasDest | input | 1 | Instruction writes a register |
| renIsBranch | input | 1 | Instruction is a branch needing a checkpoint |
| renDst | input | 5 | Logical destination |
| renSrcA | input | 5 | Logical source A |
| renSrcB | input | 5 | Logical source B |
| renReady | output | 1 | Offered instruction is accepted this cycle |
| physSrcA | output | 6 | Physical register for source A |
| physSrcB | output | 6 | Physical register for source B |
| physDst | output | 6 | Physical register assigned to the destination |
| physPrev | output | 6 | Current mapping of renDst |
| brTag | output | 2 | Checkpoint slot given to the branch |
| commitValid | input | 1 | Retire the oldest history entry |
| brValid | input | 1 | Branch resolution strobe |
| brMispredict | input | 1 | Resolved branch was mispredicted |
| brResTag | input | 2 | Checkpoint slot of the resolved branch |
| excValid | input | 1 | Exception: roll back all uncommitted entries |

## Verification
The hardest case is a mispredict that arrives while younger checkpoints are live, after several allocations and some commits. The restored free set must then combine registers freed by commit after the snapshot with registers allocated after it. A long random stream builds up this state by mixing renames, branches, commits, correct resolutions, mispredicts and occasional exceptions. A reference model derived from the requirements predicts every output. The full mapping is read back periodically through the source ports. Directed cases cover exhausting physical registers, a full history, a full checkpoint set, and recovery arriving in the same cycle as a rename attempt.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int NLOG   = 32;
  parameter int NPHYS  = 64;
  parameter int NCKPT  = 4;
  parameter int HDEPTH = 64;

  localparam int LW = $clog2(NLOG);
  localparam int PW = $clog2(NPHYS);
  localparam int CW = $clog2(NCKPT);
  localparam int HW = $clog2(HDEPTH);

  typedef logic [LW-1:0] lregT;
  typedef logic [PW-1:0] pregT;
  typedef logic [CW-1:0] ctagT;
  typedef logic [HW-1:0] hidxT;
  typedef logic [HW:0]   hptrT;

  // strobes from control to datapath
  typedef struct packed {
    logic             rename;
    logic             allocDst;
    logic             takeCkpt;
    ctagT             ckptSlot;
    hidxT             tailIdx;
    logic             commit;
    hidxT             headIdx;
    logic             restore;
    ctagT             restoreSlot;
    logic             undo;
    hidxT             undoIdx;
    logic [NCKPT-1:0] live;
  } strobeT;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl import rn_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   renValid,
  input  logic   renHasDest,
  input  logic   renIsBranch,
  input  logic   commitValid,
  input  logic   brValid,
  input  logic   brMispredict,
  input  ctagT   brResTag,
  input  logic   excValid,
  input  logic   freeAny,
  output logic   renReady,
  output ctagT   brTag,
  output strobeT st
);
  hptrT headPtr, tailPtr, used;
  logic histFull, histEmpty;
  logic [NCKPT-1:0] live, liveNext;
  logic [NCKPT-1:0] younger [NCKPT];
  hptrT ckptTail [NCKPT];
  logic walking, mispredict, slotAny;
  ctagT freeSlot;

  always_comb begin
    used      = tailPtr - headPtr;
    histFull  = (used == hptrT'(HDEPTH));
    histEmpty = (used == '0);
    freeSlot  = '0;
    slotAny   = 1'b0;
    for (int k = NCKPT - 1; k >= 0; k--) begin
      if (!live[k]) begin
        freeSlot = ctagT'(k);
        slotAny  = 1'b1;
      end
    end
    mispredict = brValid && brMispredict && !walking;
    renReady   = !walking && !excValid && !mispredict && !histFull &&
                 (renIsBranch ? slotAny : (!renHasDest || freeAny));
    brTag = freeSlot;

    st             = '0;
    st.rename      = renValid && renReady;
    st.allocDst    = st.rename && renHasDest && !renIsBranch;
    st.takeCkpt    = st.rename && renIsBranch;
    st.ckptSlot    = freeSlot;
    st.tailIdx     = hidxT'(tailPtr);
    st.commit      = commitValid && !walking && !excValid && !mispredict && !histEmpty;
    st.headIdx     = hidxT'(headPtr);
    st.restore     = mispredict && !excValid;
    st.restoreSlot = brResTag;
    st.undo        = walking && !histEmpty;
    st.undoIdx     = hidxT'(tailPtr - 1'b1);
    st.live        = live;

    liveNext = live;
    if (brValid && !brMispredict) liveNext[brResTag] = 1'b0;
    if (st.takeCkpt) liveNext[freeSlot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
      live    <= '0;
      walking <= 1'b0;
    end else if (walking) begin
      if (histEmpty) walking <= 1'b0;
      else           tailPtr <= tailPtr - 1'b1;
    end else if (excValid) begin
      walking <= 1'b1;
      live    <= '0;
    end else if (mispredict) begin
      tailPtr <= ckptTail[brResTag];
      live    <= live & ~(younger[brResTag] |
                          ({{(NCKPT-1){1'b0}}, 1'b1} << brResTag));
    end else begin
      if (st.rename) tailPtr <= tailPtr + 1'b1;
      if (st.commit) headPtr <= headPtr + 1'b1;
      live <= liveNext;
    end
  end

  // checkpoint bookkeeping: history position and age order
  always_ff @(posedge clk) begin
    if (st.takeCkpt) begin
      ckptTail[freeSlot] <= tailPtr + 1'b1;
      younger[freeSlot]  <= '0;
      for (int j = 0; j < NCKPT; j++) begin
        if (live[j]) younger[j][freeSlot] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rename_datapath.sv
module rename_datapath import rn_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  strobeT st,
  input  lregT   renDst,
  input  lregT   renSrcA,
  input  lregT   renSrcB,
  output pregT   physSrcA,
  output pregT   physSrcB,
  output pregT   physDst,
  output pregT   physPrev,
  output logic   freeAny
);
  pregT mapTbl [NLOG];
  logic [NPHYS-1:0] freeVec;
  lregT histLog  [HDEPTH];
  pregT histNew  [HDEPTH];
  pregT histPrev [HDEPTH];
  logic histHas  [HDEPTH];
  pregT ckptMap  [NCKPT][NLOG];
  logic [NPHYS-1:0] allocMask [NCKPT];

  always_comb begin
    physSrcA = mapTbl[renSrcA];
    physSrcB = mapTbl[renSrcB];
    physPrev = mapTbl[renDst];
    physDst  = '0;
    for (int i = NPHYS - 1; i >= 0; i--) begin
      if (freeVec[i]) physDst = pregT'(i);
    end
    freeAny = |freeVec;
  end

  // per-checkpoint record of registers handed out after the snapshot
  for (genvar c = 0; c < NCKPT; c++) begin : g_mask
    logic [NPHYS-1:0] maskQ;
    always_ff @(posedge clk) begin
      if (st.takeCkpt && st.ckptSlot == ctagT'(c)) maskQ <= '0;
      else if (st.allocDst && st.live[c])         maskQ[physDst] <= 1'b1;
    end
    assign allocMask[c] = maskQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLOG; i++) mapTbl[i] <= pregT'(i);
      for (int i = 0; i < NPHYS; i++) freeVec[i] <= (i >= NLOG);
    end else if (st.undo) begin
      if (histHas[st.undoIdx]) begin
        mapTbl[histLog[st.undoIdx]]   <= histPrev[st.undoIdx];
        freeVec[histNew[st.undoIdx]]  <= 1'b1;
      end
    end else if (st.restore) begin
      for (int i = 0; i < NLOG; i++) mapTbl[i] <= ckptMap[st.restoreSlot][i];
      freeVec <= freeVec | allocMask[st.restoreSlot];
    end else begin
      if (st.allocDst) begin
        mapTbl[renDst]   <= physDst;
        freeVec[physDst] <= 1'b0;
      end
      if (st.commit && histHas[st.headIdx])
        freeVec[histPrev[st.headIdx]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st.rename) begin
      histLog[st.tailIdx]  <= renDst;
      histNew[st.tailIdx]  <= physDst;
      histPrev[st.tailIdx] <= physPrev;
      histHas[st.tailIdx]  <= st.allocDst;
    end
    if (st.takeCkpt) begin
      for (int i = 0; i < NLOG; i++) ckptMap[st.ckptSlot][i] <= mapTbl[i];
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit import rn_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       renValid,
  input  logic       renHasDest,
  input  logic       renIsBranch,
  input  logic [4:0] renDst,
  input  logic [4:0] renSrcA,
  input  logic [4:0] renSrcB,
  output logic       renReady,
  output logic [5:0] physSrcA,
  output logic [5:0] physSrcB,
  output logic [5:0] physDst,
  output logic [5:0] physPrev,
  output logic [1:0] brTag,
  input  logic       commitValid,
  input  logic       brValid,
  input  logic       brMispredict,
  input  logic [1:0] brResTag,
  input  logic       excValid
);
  strobeT st;
  logic   freeAny;

  rename_ctrl u_ctrl (
    .clk, .rst_n, .renValid, .renHasDest, .renIsBranch, .commitValid,
    .brValid, .brMispredict, .brResTag, .excValid, .freeAny,
    .renReady, .brTag, .st
  );

  rename_datapath u_dp (
    .clk, .rst_n, .st, .renDst, .renSrcA, .renSrcB,
    .physSrcA, .physSrcB, .physDst, .physPrev, .freeAny
  );
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       renValid,
  input logic       renHasDest,
  input logic       renIsBranch,
  input logic [4:0] renDst,
  input logic [4:0] renSrcA,
  input logic       renReady,
  input logic [5:0] physSrcA,
  input logic [5:0] physDst,
  input logic [5:0] physPrev,
  input logic [1:0] brTag,
  input logic       brValid,
  input logic       brMispredict,
  input logic       excValid
);
  logic accDst, accBr;
  assign accDst = renValid && renReady && renHasDest && !renIsBranch;
  assign accBr  = renValid && renReady && renIsBranch;

  // R3: a new register never equals the one it replaces
  a_r3_fresh_reg: assert property (@(posedge clk) disable iff (!rst_n)
    accDst |-> (physDst != physPrev));

  // R3: back-to-back destinations get distinct registers
  a_r3_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    accDst |=> (!accDst || physDst != $past(physDst)));

  // R2: a just-renamed destination is seen by the next reader
  a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
    accDst |=> ((renSrcA != $past(renDst)) || (physSrcA == $past(physDst))));

  // R6: consecutive branches occupy different slots
  a_r6_slot_unique: assert property (@(posedge clk) disable iff (!rst_n)
    accBr |=> (!accBr || brTag != $past(brTag)));

  // R10: recovery blocks renaming in the same cycle
  a_r10_block: assert property (@(posedge clk) disable iff (!rst_n)
    (excValid || (brValid && brMispredict)) |-> !renReady);
endmodule

bind rename_unit rename_unit_chk u_chk (.*);

// File: tb/sim_rename_unit.sv
`timescale 1ns/1ps
module sim_rename_unit;
  import rn_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic renValid = 0, renHasDest = 0, renIsBranch = 0;
  logic [4:0] renDst = 0, renSrcA = 0, renSrcB = 0;
  logic renReady;
  logic [5:0] physSrcA, physSrcB, physDst, physPrev;
  logic [1:0] brTag;
  logic commitValid = 0, brValid = 0, brMispredict = 0, excValid = 0;
  logic [1:0] brResTag = 0;

  rename_unit u0 (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;

  // reference model
  int mMap [NLOG];
  bit mFree [NPHYS];
  int hLog [HDEPTH], hNew [HDEPTH], hPrev [HDEPTH], hTag [HDEPTH], hSeq [HDEPTH];
  bit hHas [HDEPTH], hBr [HDEPTH];
  int mHead, mTail, seqCtr;
  bit mLive [NCKPT];
  int mSeqOf [NCKPT], mCkTail [NCKPT];
  int mCkMap [NCKPT][NLOG];
  bit mCkAlloc [NCKPT][NPHYS];
  int lastDst, lastSrcA, lastTag;

  // dst, srcA, srcB, expected physDst, expected physSrcA (from reset)
  localparam int VEC [6][5] = '{
    '{1, 1, 2, 32, 1}, '{2, 1, 2, 33, 32}, '{1, 1, 1, 34, 32},
    '{5, 2, 3, 35, 33}, '{2, 5, 1, 36, 35}, '{0, 2, 2, 37, 36}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowFree();
    for (int p = 0; p < NPHYS; p++) if (mFree[p]) return p;
    return -1;
  endfunction

  function automatic int lowSlot();
    for (int c = 0; c < NCKPT; c++) if (!mLive[c]) return c;
    return -1;
  endfunction

  function automatic bit canCommit();
    int i;
    if (mTail == mHead) return 0;
    i = mHead % HDEPTH;
    if (hBr[i] && mLive[hTag[i]] && mSeqOf[hTag[i]] == hSeq[i]) return 0;
    return 1;
  endfunction

  task automatic clearIn();
    renValid = 0; renHasDest = 0; renIsBranch = 0; renDst = 0; renSrcA = 0; renSrcB = 0;
    commitValid = 0; brValid = 0; brMispredict = 0; brResTag = 0; excValid = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    clearIn();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NLOG; i++) mMap[i] = i;
    for (int p = 0; p < NPHYS; p++) mFree[p] = (p >= NLOG);
    for (int c = 0; c < NCKPT; c++) mLive[c] = 0;
    mHead = 0; mTail = 0; seqCtr = 0;
  endtask

  task automatic doRen(bit hd, bit br, int d, int a, int b, string req);
    int f, s, idx;
    bit er;
    @(negedge clk);
    clearIn();
    renValid = 1; renHasDest = hd; renIsBranch = br;
    renDst = 5'(d); renSrcA = 5'(a); renSrcB = 5'(b);
    #1;
    f = lowFree(); s = lowSlot();
    er = (mTail - mHead < HDEPTH) && (br ? (s >= 0) : (!hd || f >= 0));
    chk(req, int'(renReady), int'(er));
    if (er) begin
      chk("R2 srcA", physSrcA, mMap[a]);
      chk("R2 srcB", physSrcB, mMap[b]);
      lastDst = physDst; lastSrcA = physSrcA; lastTag = brTag;
      idx = mTail % HDEPTH;
      hLog[idx] = d; hHas[idx] = hd && !br; hBr[idx] = br;
      if (br) begin
        chk("R6 slot", brTag, s);
        seqCtr++;
        mLive[s] = 1; mSeqOf[s] = seqCtr; hTag[idx] = s; hSeq[idx] = seqCtr;
        for (int i = 0; i < NLOG; i++) mCkMap[s][i] = mMap[i];
        for (int p = 0; p < NPHYS; p++) mCkAlloc[s][p] = 0;
        mCkTail[s] = mTail + 1;
      end else if (hd) begin
        chk("R3 dest", physDst, f);
        chk("R2 prev", physPrev, mMap[d]);
        hNew[idx] = f; hPrev[idx] = mMap[d];
        mMap[d] = f; mFree[f] = 0;
        for (int c = 0; c < NCKPT; c++) if (mLive[c]) mCkAlloc[c][f] = 1;
      end
      mTail++;
    end
    @(posedge clk);
  endtask

  task automatic doCommit();
    int idx;
    @(negedge clk);
    clearIn();
    commitValid = 1;
    @(posedge clk);
    if (mTail > mHead) begin
      idx = mHead % HDEPTH;
      if (hHas[idx]) mFree[hPrev[idx]] = 1;
      mHead++;
    end
  endtask

  task automatic doResolve(int t, bit mis);
    @(negedge clk);
    clearIn();
    brValid = 1; brMispredict = mis; brResTag = 2'(t);
    if (mis) begin
      renValid = 1; renHasDest = 1; renDst = 5'd6; commitValid = 1;
      #1 chk("R10 mispredict", int'(renReady), 0);
    end
    @(posedge clk);
    if (!mis) mLive[t] = 0;
    else begin
      for (int i = 0; i < NLOG; i++) mMap[i] = mCkMap[t][i];
      for (int p = 0; p < NPHYS; p++) if (mCkAlloc[t][p]) mFree[p] = 1;
      mTail = mCkTail[t];
      for (int c = 0; c < NCKPT; c++) if (mLive[c] && mSeqOf[c] > mSeqOf[t]) mLive[c] = 0;
      mLive[t] = 0;
    end
  endtask

  task automatic doExc();
    int idx, pending;
    @(negedge clk);
    clearIn();
    excValid = 1; renValid = 1; renHasDest = 1; renDst = 5'd5; commitValid = 1;
    #1 chk("R10 exception", int'(renReady), 0);
    @(posedge clk);
    pending = mTail - mHead;
    while (mTail > mHead) begin
      mTail--;
      idx = mTail % HDEPTH;
      if (hHas[idx]) begin
        mMap[hLog[idx]] = hPrev[idx];
        mFree[hNew[idx]] = 1;
      end
    end
    for (int c = 0; c < NCKPT; c++) mLive[c] = 0;
    @(negedge clk);
    clearIn();
    #1;
    if (pending > 0) chk("R9 stall during walk", int'(renReady), 0);
    for (int w = 0; w < 200 && !renReady; w++) begin
      @(negedge clk);
      #1;
    end
    chk("R9 walk ends", int'(renReady), 1);
  endtask

  task automatic probe(string req);
    for (int i = 0; i < NLOG / 2; i++) begin
      @(negedge clk);
      clearIn();
      renSrcA = 5'(2 * i); renSrcB = 5'(2 * i + 1);
      #1;
      chk(req, physSrcA, mMap[2 * i]);
      chk(req, physSrcB, mMap[2 * i + 1]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    probe("R1 identity map");
    for (int k = 0; k < 6; k++) begin
      doRen(1, 0, VEC[k][0], VEC[k][1], VEC[k][2], "R4 ready");
      chk("R3 table dest", lastDst, VEC[k][3]);
      chk("R2 table srcA", lastSrcA, VEC[k][4]);
    end
    doRen(1, 0, 3, 3, 3, "R4 ready");
    chk("R2 self source", lastSrcA, 3);

    // R5: commit on empty history
    doReset();
    doCommit();
    doRen(1, 0, 0, 0, 0, "R4 ready");
    chk("R5 empty commit", lastDst, 32);
    probe("R5 map");

    // R4: physical registers exhausted
    doReset();
    for (int i = 0; i < 32; i++) doRen(1, 0, i, 0, 0, "R4 ready");
    doRen(1, 0, 7, 0, 0, "R4 no free reg");
    doCommit();
    doRen(1, 0, 7, 0, 0, "R4 ready");
    chk("R5 freed prev", lastDst, 0);

    // R4: history full
    doReset();
    for (int i = 0; i < HDEPTH; i++) doRen(0, 0, 0, 1, 2, "R4 ready");
    doRen(0, 0, 0, 1, 2, "R4 history full");
    doCommit();
    doRen(0, 0, 0, 1, 2, "R4 ready after commit");

    // R6 / R7: checkpoint slots
    doReset();
    for (int i = 0; i < NCKPT; i++) doRen(0, 1, 0, 0, 0, "R6 ready");
    doRen(0, 1, 0, 0, 0, "R6 slots full");
    doResolve(1, 0);
    doRen(0, 1, 0, 0, 0, "R7 ready");
    chk("R7 reuse slot", lastTag, 1);
    probe("R7 map unchanged");

    // R8: mispredict restore
    doReset();
    doRen(1, 0, 3, 0, 0, "R4 ready");
    doRen(0, 1, 0, 0, 0, "R6 ready");
    doRen(1, 0, 3, 0, 0, "R4 ready");
    doRen(1, 0, 4, 0, 0, "R4 ready");
    doResolve(0, 1);
    probe("R8 restored map");
    doRen(1, 0, 7, 0, 0, "R4 ready");
    chk("R8 regs returned", lastDst, 33);

    // R9: exception rollback
    doReset();
    doRen(1, 0, 1, 0, 0, "R4 ready");
    doRen(1, 0, 2, 0, 0, "R4 ready");
    doCommit();
    doRen(0, 1, 0, 0, 0, "R6 ready");
    doRen(1, 0, 1, 0, 0, "R4 ready");
    doExc();
    probe("R9 rolled back map");
    doRen(1, 0, 9, 0, 0, "R4 ready");
    chk("R9 lowest after rollback", lastDst, 1);
    doRen(0, 1, 0, 0, 0, "R6 ready");
    chk("R9 slots released", lastTag, 0);

    // random stream against the model
    doReset();
    for (int n = 0; n < 3000; n++) begin
      int r, t;
      r = $urandom % 100;
      if (r < 30) doRen(1, 0, $urandom % NLOG, $urandom % NLOG, $urandom % NLOG, "R4 random ready");
      else if (r < 35) doRen(0, 0, 0, $urandom % NLOG, $urandom % NLOG, "R4 random ready");
      else if (r < 42) doRen(0, 1, 0, $urandom % NLOG, $urandom % NLOG, "R6 random ready");
      else if (r < 75) begin
        if (canCommit()) doCommit();
      end else if (r < 93) begin
        t = $urandom % NCKPT;
        if (mLive[t]) doResolve(t, r >= 85);
      end else if (r == 93 && (n % 3 == 0)) doExc();
      else begin
        @(negedge clk);
        clearIn();
      end
      if (n % 250 == 249) probe("R8 random map");
    end
    probe("R8 final map");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule